// File: doc/BRIEF.md
# IR Sample Stream Packet Parser

This block sits behind an infrared receiver's byte buffer and splits the incoming byte stream into two kinds of packets. Run-length data packets begin with a data header whose low five bits give the number of sample bytes that follow. Each sample byte becomes one output event: a pulse/space flag and a duration in microseconds. Command packets begin with any other header byte, carry a subcommand byte and a payload whose length is fixed by the header/subcommand pair. The block consumes and drops them without producing events.

A data header that declares zero samples is reported on a one-cycle overflow strobe, and parsing continues in the header state. The block accepts one byte per cycle when `in_valid` is high. Every output is registered and appears in the cycle after the byte that caused it. The parser has four named states:
- `ST_HDR` (header)
- `ST_SUB` (subcommand)
- `ST_CMD` (command payload)
- `ST_DATA` (IR samples)

Its transitions are:
- HDR→DATA on a data header with nonzero length.
- HDR→HDR on a zero-length data header.
- HDR→SUB on any other byte.
- SUB→CMD when the looked-up payload is nonzero, otherwise SUB→HDR.
- CMD→HDR and DATA→HDR when the remaining count reaches zero.

Top module: `ir_pkt_parser`

## Requirements
- R1: After synchronous reset, `ev_valid` and `ev_ovf` are 0 and the next byte is treated as a header.
- R2: A header byte is a data header when (byte & 0xE0) == 0x80 and byte != 0x9F. Its low five bits give the number of following sample bytes.
- R3: A data header with length 0 (byte 0x80) raises `ev_ovf` for exactly one cycle, in the cycle after the byte, and produces no event. The next byte is again a header.
- R4: A sample byte gives `ev_pulse` = bit 7 and `ev_dur` = bits 6:0 × 50.
- R5: Header byte 0x9F, and any byte failing the R2 test, starts a command packet. The following byte is a subcommand, and no event is produced for either byte.
- R6: Payload lengths after the subcommand are as follows:
  - header 0x00 with subcommand 0xFF takes 1 byte.
  - header 0xFF with subcommand 0x0B takes 2 bytes.
  - header 0x9F with subcommand 0x06, 0x0C or 0x15 takes 2 bytes.
  - header 0x9F with subcommand 0x01, 0x08 or 0x14 takes 1 byte.
  
  Payload bytes produce no events, and the byte after the payload is a header.
- R7: Any other header/subcommand pair has a zero-length payload, so the byte right after the subcommand is a header.
- R8: `ev_valid` is high for exactly one cycle per sample byte, in the cycle after that byte is accepted, and never together with `ev_ovf`.
- R9: Cycles with `in_valid` low neither advance the parser nor produce `ev_valid` or `ev_ovf`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_byte` is presented this cycle |
| in_byte | input | 8 | Stream byte |
| ev_valid | output | 1 | One-cycle event strobe |
| ev_pulse | output | 1 | 1 = pulse, 0 = space |
| ev_dur | output | 16 | Event duration in microseconds |
| ev_ovf | output | 1 | One-cycle zero-length-header strobe |

## Verification
The bench targets the header byte 0x9F. It matches the data-header mask, so a parser that tested only the mask would turn a command packet into a run of bogus events. It drives every listed header/subcommand pair and also unlisted pairs. A wrong length table would either swallow the next data header or turn command payload bytes into events. It covers zero-length headers, where a parser that entered the data state would wait for samples that never come. It also inserts idle gaps inside packets, which would shift the packet framing if idle cycles advanced the state.

// File: rtl/ir_pkt_pkg.sv
package ir_pkt_pkg;

    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_SUB  = 2'd1,
        ST_CMD  = 2'd2,
        ST_DATA = 2'd3
    } pstate_t;

    localparam logic [7:0] HDR_CMD      = 8'h9F;
    localparam logic [7:0] HDR_HWCMD    = 8'hFF;
    localparam logic [7:0] HDR_NULL     = 8'h00;
    localparam logic [7:0] HDR_CLS_MASK = 8'hE0;
    localparam logic [7:0] HDR_CLS_DATA = 8'h80;

    localparam logic [7:0] SC_REVISION  = 8'h0B;
    localparam logic [7:0] SC_CARRIER   = 8'h06;
    localparam logic [7:0] SC_TIMEOUT   = 8'h0C;
    localparam logic [7:0] SC_SIGEND    = 8'h01;
    localparam logic [7:0] SC_TXMASK    = 8'h08;
    localparam logic [7:0] SC_RXSENSOR  = 8'h14;
    localparam logic [7:0] SC_PULSECNT  = 8'h15;

endpackage

// File: rtl/ir_len_lookup.sv
module ir_len_lookup
    import ir_pkt_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input  logic [7:0]       hdr,
    input  logic [7:0]       sub,
    output logic [LEN_W-1:0] len
);
    always_comb begin
        len = '0;
        if (hdr == HDR_NULL) begin
            if (sub == HDR_HWCMD) len = LEN_W'(1);
        end else if (hdr == HDR_HWCMD) begin
            if (sub == SC_REVISION) len = LEN_W'(2);
        end else if (hdr == HDR_CMD) begin
            if (sub == SC_CARRIER || sub == SC_TIMEOUT || sub == SC_PULSECNT)
                len = LEN_W'(2);
            else if (sub == SC_SIGEND || sub == SC_TXMASK || sub == SC_RXSENSOR)
                len = LEN_W'(1);
        end
    end
endmodule

// File: rtl/ir_sample_scale.sv
module ir_sample_scale #(
    parameter int CNT_W   = 7,
    parameter int DUR_W   = 16,
    parameter int UNIT_US = 50
) (
    input  logic [CNT_W-1:0] count,
    output logic [DUR_W-1:0] dur
);
    localparam logic [DUR_W-1:0] UNIT = DUR_W'(UNIT_US);
    assign dur = DUR_W'(count) * UNIT;
endmodule

// File: rtl/ir_pkt_parser.sv
module ir_pkt_parser
    import ir_pkt_pkg::*;
#(
    parameter int DUR_W   = 16,
    parameter int UNIT_US = 50,
    parameter int LEN_W   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             ev_valid,
    output logic             ev_pulse,
    output logic [DUR_W-1:0] ev_dur,
    output logic             ev_ovf
);
    localparam int CNT_W = 7;

    pstate_t          state, nxt_state;
    logic [7:0]       cmd_q, nxt_cmd;
    logic [LEN_W-1:0] rem_q, nxt_rem;
    logic [LEN_W-1:0] tbl_len;
    logic [LEN_W-1:0] hdr_len;
    logic [DUR_W-1:0] scaled;
    logic             is_data_hdr;
    logic             take_sample;
    logic             zero_hdr;

    ir_len_lookup #(.LEN_W(LEN_W)) i_len (
        .hdr (cmd_q),
        .sub (in_byte),
        .len (tbl_len)
    );

    ir_sample_scale #(.CNT_W(CNT_W), .DUR_W(DUR_W), .UNIT_US(UNIT_US)) i_scale (
        .count (in_byte[CNT_W-1:0]),
        .dur   (scaled)
    );

    assign is_data_hdr = ((in_byte & HDR_CLS_MASK) == HDR_CLS_DATA) && (in_byte != HDR_CMD);
    assign hdr_len     = in_byte[LEN_W-1:0];
    assign take_sample = in_valid && (state == ST_DATA);
    assign zero_hdr    = in_valid && (state == ST_HDR) && is_data_hdr && (hdr_len == '0);

    always_comb begin
        nxt_state = state;
        nxt_cmd   = cmd_q;
        nxt_rem   = rem_q;
        if (in_valid) begin
            unique case (state)
                ST_HDR: begin
                    if (is_data_hdr) begin
                        nxt_rem = hdr_len;
                        if (hdr_len != '0) nxt_state = ST_DATA;
                    end else begin
                        nxt_cmd   = in_byte;
                        nxt_state = ST_SUB;
                    end
                end
                ST_SUB: begin
                    nxt_rem   = tbl_len;
                    nxt_state = (tbl_len == '0) ? ST_HDR : ST_CMD;
                end
                ST_CMD, ST_DATA: begin
                    nxt_rem = rem_q - 1'b1;
                    if (rem_q == LEN_W'(1)) nxt_state = ST_HDR;
                end
                default: nxt_state = ST_HDR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HDR;
            cmd_q <= '0;
            rem_q <= '0;
        end else begin
            state <= nxt_state;
            cmd_q <= nxt_cmd;
            rem_q <= nxt_rem;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_valid <= 1'b0;
            ev_pulse <= 1'b0;
            ev_dur   <= '0;
            ev_ovf   <= 1'b0;
        end else begin
            ev_valid <= take_sample;
            ev_ovf   <= zero_hdr;
            if (take_sample) begin
                ev_pulse <= in_byte[7];
                ev_dur   <= scaled;
            end
        end
    end
endmodule

// File: rtl/ir_pkt_parser_chk.sv
module ir_pkt_parser_chk #(
    parameter int DUR_W   = 16,
    parameter int UNIT_US = 50
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [7:0]       in_byte,
    input logic             ev_valid,
    input logic             ev_pulse,
    input logic [DUR_W-1:0] ev_dur,
    input logic             ev_ovf
);
    a_r8_event_needs_byte: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> $past(in_valid));

    a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(ev_valid && ev_ovf));

    a_r4_pulse_flag: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> (ev_pulse == $past(in_byte[7])));

    a_r4_duration: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> (ev_dur == DUR_W'($past(in_byte[6:0])) * DUR_W'(UNIT_US)));

    a_r3_ovf_source: assert property (@(posedge clk) disable iff (rst)
        ev_ovf |-> ($past(in_valid) && $past(in_byte) == 8'h80));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!ev_valid && !ev_ovf));
endmodule

bind ir_pkt_parser ir_pkt_parser_chk #(.DUR_W(DUR_W), .UNIT_US(UNIT_US)) i_chk (.*);

// File: tb/test_ir_pkt_parser.sv
`timescale 1ns/1ps
module test_ir_pkt_parser;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        ev_valid, ev_pulse, ev_ovf;
    logic [15:0] ev_dur;

    int checks = 0;
    int fails  = 0;

    int         m_st  = 0;   // 0 hdr, 1 sub, 2 cmd payload, 3 samples
    logic [7:0] m_cmd = 8'h00;
    int         m_rem = 0;

    always #10 clk = ~clk;

    ir_pkt_parser i_ir_pkt_parser (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .ev_valid(ev_valid), .ev_pulse(ev_pulse), .ev_dur(ev_dur), .ev_ovf(ev_ovf)
    );

    function automatic int exp_len(input logic [7:0] h, input logic [7:0] s);
        if (h == 8'h00 && s == 8'hFF) return 1;
        if (h == 8'hFF && s == 8'h0B) return 2;
        if (h == 8'h9F && (s == 8'h06 || s == 8'h0C || s == 8'h15)) return 2;
        if (h == 8'h9F && (s == 8'h01 || s == 8'h08 || s == 8'h14)) return 1;
        return 0;
    endfunction

    function automatic bit data_hdr(input logic [7:0] b);
        return (b[7:5] == 3'b100) && (b != 8'h9F);
    endfunction

    task automatic check(input string tag, input bit ev, input bit pl,
                         input logic [15:0] du, input bit ov);
        checks++;
        if (ev_valid !== ev || ev_ovf !== ov || (ev && (ev_pulse !== pl || ev_dur !== du))) begin
            fails++;
            $display("FAIL %s: got v=%0b p=%0b d=%0d o=%0b, expected v=%0b p=%0b d=%0d o=%0b",
                     tag, ev_valid, ev_pulse, ev_dur, ev_ovf, ev, pl, du, ov);
        end
    endtask

    task automatic push(input logic [7:0] b, input string tag);
        bit ev = 0, ov = 0, pl = 0;
        logic [15:0] du = 0;
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        case (m_st)
            0: if (data_hdr(b)) begin
                   m_rem = b[4:0];
                   if (m_rem == 0) ov = 1; else m_st = 3;
               end else begin
                   m_cmd = b; m_st = 1;
               end
            1: begin m_rem = exp_len(m_cmd, b); m_st = (m_rem == 0) ? 0 : 2; end
            2: begin m_rem--; if (m_rem == 0) m_st = 0; end
            default: begin
                ev = 1; pl = b[7]; du = 16'(b[6:0]) * 16'd50;
                m_rem--; if (m_rem == 0) m_st = 0;
            end
        endcase
        @(posedge clk);
        #1;
        check(tag, ev, pl, du, ov);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_byte  = 8'h80;
            @(posedge clk);
            #1;
            check("R9 idle", 0, 0, 0, 0);
        end
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] subs [8] = '{8'h0B, 8'h06, 8'h0C, 8'h01, 8'h08, 8'h14, 8'h15, 8'hFF};
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 0, 0, 0, 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 after reset", 0, 0, 0, 0);

        // R2 / R4: three samples, including extremes of the count field
        push(8'h83, "R2 header");
        push(8'h85, "R4 pulse");
        push(8'h00, "R4 zero space");
        push(8'hFF, "R4 max pulse");
        // R3: zero length header, then a header is expected again
        push(8'h80, "R3 overflow");
        push(8'h81, "R3 next is header");
        push(8'h7F, "R4 max space");
        // R5: 0x9F is a command, not data
        push(8'h9F, "R5 cmd header");
        push(8'h06, "R6 carrier sub");
        push(8'h85, "R6 payload1");
        push(8'h90, "R6 payload2");
        push(8'h82, "R6 header after payload");
        push(8'h8A, "R4 sample");
        idle(2);
        push(8'h0A, "R9 sample after gap");
        // R6 other table rows
        push(8'hFF, "R5 hw cmd");
        push(8'h0B, "R6 revision");
        push(8'h81, "R6 rev payload1");
        push(8'h83, "R6 rev payload2");
        push(8'h00, "R5 null cmd");
        push(8'hFF, "R6 null sub");
        push(8'h84, "R6 null payload");
        // R7: unlisted pair
        push(8'h9F, "R5 cmd header");
        push(8'h02, "R7 unknown sub");
        push(8'h81, "R7 header next");
        push(8'h99, "R4 sample");
        push(8'hA1, "R2 mask miss is cmd");
        push(8'h0B, "R7 sub zero len");
        push(8'h80, "R3 overflow again");

        // constrained random stream
        for (int i = 0; i < 3000; i++) begin
            int k = $urandom_range(0, 9);
            logic [7:0] b;
            if (m_st == 0)
                b = (k < 4) ? {3'b100, 5'($urandom_range(0, 6))} :
                    (k < 6) ? 8'h9F : (k < 7) ? 8'hFF : (k < 8) ? 8'h00 : 8'($urandom);
            else if (m_st == 1)
                b = (k < 7) ? subs[$urandom_range(0, 7)] : 8'($urandom);
            else
                b = 8'($urandom);
            push(b, (m_st == 3) ? "R4 random sample" : (m_st == 0 && b == 8'h80) ?
                 "R3 random ovf" : "R6 random framing");
            if ($urandom_range(0, 7) == 0) idle(1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule